// File: doc/BRIEF.md
# Receive Character Queue with Status Flags

This block buffers decoded receive characters in a 256-entry first-in first-out store. Every character is nine bits wide: an eight-bit value and a one-bit tag. The tag is 1 for a command character and 0 for a data character. A single clock drives both the write side and the read side. Three status pins report the fill level: empty, half-full and almost-full. A strap input sets the active sense of the empty and almost-full pins. An output-enable input holds every status pin at its inactive level and forces the read bus to zero.

The store can be cleared on its own, without a chip reset. A small qualifier state machine watches the clear request and acts only after the request has been sampled high on seven consecutive clocks. Its states are `Q_RUN`, `Q_ARM` and `Q_HELD`. From `Q_RUN`, the first high sample of the request moves it to `Q_ARM`. In `Q_ARM`, a low sample returns it to `Q_RUN`, and the seventh consecutive high sample moves it to `Q_HELD`. On that same edge the store is emptied. The machine stays in `Q_HELD` while the request stays high, and a low sample returns it to `Q_RUN`.

A bypass mode skips the store. Each written character goes straight to the read bus on the next clock. In this mode the empty and almost-full pins serve as character-valid indicators.

Top module: `char_rx_fifo`

## Requirements
- R1: After the chip reset, with oe high and pol_hi high, flag_empty is 1, flag_half is 0, flag_full is 0, ovf_flag is 0, and rd_char and rd_cmd are 0.
- R2: Outside bypass, characters are read in the order they were written, with their tag (rd_cmd is 1 for command, 0 for data). A read accepted at a clock edge shows its character on rd_char and rd_cmd right after that edge.
- R3: A write attempted while 256 characters are stored is dropped and sets ovf_flag. ovf_flag then stays set until the store is cleared by a qualified clear.
- R4: A read attempted while the store is empty changes neither the flags nor the occupancy, and rd_char and rd_cmd keep the last value read.
- R5: Outside bypass, the empty condition is active exactly when zero characters are stored.
- R6: Outside bypass, the half-full condition is active exactly when 128 or more characters are stored. flag_half is always active high.
- R7: Outside bypass, the almost-full condition is active exactly when four or fewer free slots remain, which means 252 or more characters are stored.
- R8: A read and a write in the same cycle, while between 1 and 255 characters are stored, leave the occupancy unchanged.
- R9: fifo_rst_req clears the store only after it has been sampled high on 7 consecutive clocks; 6 samples have no effect. Once the clear is in effect, the store is empty, flag_half is inactive, ovf_flag is 0, and writes are ignored until the request drops.
- R10: With pol_hi = 1, flag_empty and flag_full are active high. With pol_hi = 0, they are active low.
- R11: In bypass, a written character appears on rd_char and rd_cmd after the next edge.
  - The almost-full condition is inactive in a cycle after a write and active otherwise.
  - The empty condition is inactive only when that character is data (tag 0).
  - flag_half stays inactive.
  - The store contents and the occupancy are untouched.
- R12: With oe low, flag_empty and flag_full sit at their inactive level (equal to !pol_hi), flag_half is 0, and rd_char and rd_cmd are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| fifo_rst_req | input | 1 | Store clear request; must be held for seven clocks to take effect |
| bypass | input | 1 | 1 selects bypass mode |
| pol_hi | input | 1 | Strap: 1 makes empty and almost-full active high |
| oe | input | 1 | Output enable for the flags and the read bus |
| wr_en | input | 1 | Write strobe |
| wr_cmd | input | 1 | Tag of the written character (1 = command) |
| wr_char | input | 8 | Written character value |
| rd_en | input | 1 | Read strobe |
| rd_char | output | 8 | Read character value |
| rd_cmd | output | 1 | Read character tag |
| flag_empty | output | 1 | Empty flag (bypass: data-not-ready) |
| flag_half | output | 1 | Half-full flag, active high |
| flag_full | output | 1 | Almost-full flag (bypass: no character ready) |
| ovf_flag | output | 1 | Sticky overflow indicator |

## Verification
The bench first fills the store one character at a time up to its limit and then drains it. After every step it checks all three flags against an occupancy counted in the bench. This walk tells apart off-by-one faults at 0, 128 and 252 characters.

A write into a full store, reads from an empty store, and paired reads and writes at the half-full boundary check three things: that overflow drops the character and not some other one, that an empty read keeps the bus, and that a paired transfer neither gains nor loses a character.

Clear requests held for six and for seven clocks show the qualifier threshold. The strap, output-enable and bypass patterns (data, command, idle) each show a different mapping of the same internal condition onto the pins.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        Q_RUN  = 2'd0,
        Q_ARM  = 2'd1,
        Q_HELD = 2'd2
    } qual_state_t;
endpackage

// File: rtl/rxq_hold_qual.sv
module rxq_hold_qual
    import rxq_pkg::*;
#(
    parameter int HOLD_CYCLES = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    output qual_state_t state,
    output logic        flush
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    qual_state_t state_nxt;
    logic [CW-1:0] hold_cnt, hold_cnt_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= Q_RUN;
            hold_cnt <= '0;
        end else begin
            state    <= state_nxt;
            hold_cnt <= hold_cnt_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt    = state;
        hold_cnt_nxt = hold_cnt;
        flush        = 1'b0;
        unique case (state)
            Q_RUN: begin
                if (req) begin
                    state_nxt    = Q_ARM;
                    hold_cnt_nxt = CW'(1);
                end
            end
            Q_ARM: begin
                if (!req) begin
                    state_nxt    = Q_RUN;
                    hold_cnt_nxt = '0;
                end else if (hold_cnt == LAST) begin
                    state_nxt    = Q_HELD;
                    hold_cnt_nxt = '0;
                    flush        = 1'b1;
                end else begin
                    hold_cnt_nxt = hold_cnt + CW'(1);
                end
            end
            Q_HELD: begin
                flush = 1'b1;
                if (!req) state_nxt = Q_RUN;
            end
            default: state_nxt = Q_RUN;
        endcase
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int WORD_W = 9,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W:0]   cnt,
    output logic              ovf
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] CNT_FULL = (ADDR_W+1)'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wptr, rptr;
    logic              full, empty, wr_ok, rd_ok;

    assign full  = (cnt == CNT_FULL);
    assign empty = (cnt == '0);
    assign wr_ok = wr_en && !full && !flush;
    assign rd_ok = rd_en && !empty && !flush;

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            cnt     <= '0;
            rd_word <= '0;
            ovf     <= 1'b0;
        end else if (flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            ovf  <= 1'b0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rd_ok) begin
                rptr    <= rptr + 1'b1;
                rd_word <= mem[rptr];
            end
            unique case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (wr_en && full) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/rxq_flag_enc.sv
module rxq_flag_enc #(
    parameter int ADDR_W      = 8,
    parameter int AFULL_SLACK = 4
) (
    input  logic            held,
    input  logic [ADDR_W:0] cnt,
    input  logic            bypass,
    input  logic            byp_valid,
    input  logic            byp_cmd,
    input  logic            pol_hi,
    input  logic            oe,
    output logic            flag_empty,
    output logic            flag_half,
    output logic            flag_full
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] HALF_MARK  = (ADDR_W+1)'(DEPTH / 2);
    localparam logic [ADDR_W:0] AFULL_MARK = (ADDR_W+1)'(DEPTH - AFULL_SLACK);

    logic empty_act, half_act, full_act;

    always_comb begin
        if (bypass) begin
            empty_act = !(byp_valid && !byp_cmd);
            half_act  = 1'b0;
            full_act  = !byp_valid;
        end else begin
            empty_act = held || (cnt == '0);
            half_act  = !held && (cnt >= HALF_MARK);
            full_act  = !held && (cnt >= AFULL_MARK);
        end
    end

    assign flag_empty = pol_hi ? (oe && empty_act) : !(oe && empty_act);
    assign flag_full  = pol_hi ? (oe && full_act)  : !(oe && full_act);
    assign flag_half  = oe && half_act;
endmodule

// File: rtl/char_rx_fifo.sv
module char_rx_fifo
    import rxq_pkg::*;
#(
    parameter int CHAR_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int AFULL_SLACK = 4,
    parameter int HOLD_CYCLES = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_rst_req,
    input  logic              bypass,
    input  logic              pol_hi,
    input  logic              oe,
    input  logic              wr_en,
    input  logic              wr_cmd,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              rd_en,
    output logic [CHAR_W-1:0] rd_char,
    output logic              rd_cmd,
    output logic              flag_empty,
    output logic              flag_half,
    output logic              flag_full,
    output logic              ovf_flag
);
    localparam int WORD_W = CHAR_W + 1;

    qual_state_t       q_state;
    logic              flush;
    logic [ADDR_W:0]   cnt;
    logic [WORD_W-1:0] fifo_word;
    logic [WORD_W-1:0] byp_word;
    logic              byp_valid;
    logic [WORD_W-1:0] out_word;

    rxq_hold_qual #(.HOLD_CYCLES(HOLD_CYCLES)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (fifo_rst_req),
        .state (q_state),
        .flush (flush)
    );

    rxq_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (wr_en && !bypass),
        .wr_word ({wr_cmd, wr_char}),
        .rd_en   (rd_en && !bypass),
        .rd_word (fifo_word),
        .cnt     (cnt),
        .ovf     (ovf_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byp_valid <= 1'b0;
            byp_word  <= '0;
        end else begin
            byp_valid <= bypass && wr_en;
            if (bypass && wr_en) byp_word <= {wr_cmd, wr_char};
        end
    end

    rxq_flag_enc #(.ADDR_W(ADDR_W), .AFULL_SLACK(AFULL_SLACK)) u_enc (
        .held       (q_state == Q_HELD),
        .cnt        (cnt),
        .bypass     (bypass),
        .byp_valid  (byp_valid),
        .byp_cmd    (byp_word[WORD_W-1]),
        .pol_hi     (pol_hi),
        .oe         (oe),
        .flag_empty (flag_empty),
        .flag_half  (flag_half),
        .flag_full  (flag_full)
    );

    assign out_word = !oe ? '0 : (bypass ? byp_word : fifo_word);
    assign rd_char  = out_word[CHAR_W-1:0];
    assign rd_cmd   = out_word[WORD_W-1];
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
    import rxq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_rst_req,
    input logic              bypass,
    input logic              pol_hi,
    input logic              oe,
    input logic              wr_en,
    input logic              rd_en,
    input logic              flag_empty,
    input logic              flag_half,
    input logic              flag_full,
    input logic              ovf_flag,
    input logic [ADDR_W:0]   cnt,
    input qual_state_t       q_state,
    input logic [WORD_W-1:0] fifo_word
);
    localparam logic [ADDR_W:0] CNT_FULL = (ADDR_W+1)'(1 << ADDR_W);

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !fifo_rst_req && wr_en && !rd_en && cnt == CNT_FULL)
        |=> (cnt == CNT_FULL && ovf_flag));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> (q_state == Q_HELD));

    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !fifo_rst_req && rd_en && !wr_en && cnt == '0)
        |=> (cnt == '0 && $stable(fifo_word)));

    p_paired_rw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !fifo_rst_req && rd_en && wr_en && cnt != '0 && cnt != CNT_FULL)
        |=> $stable(cnt));

    p_held_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_state == Q_HELD) |-> (cnt == '0 && !ovf_flag && $past(fifo_rst_req)));

    p_held_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_state == Q_HELD && !bypass && oe) |-> (flag_empty == pol_hi && !flag_half));

    p_bypass_half_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> !flag_half);

    p_oe_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (flag_empty == !pol_hi && flag_full == !pol_hi && !flag_half));
endmodule

bind char_rx_fifo rxq_checker #(.ADDR_W(ADDR_W), .WORD_W(CHAR_W + 1)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_rst_req (fifo_rst_req),
    .bypass       (bypass),
    .pol_hi       (pol_hi),
    .oe           (oe),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .flag_empty   (flag_empty),
    .flag_half    (flag_half),
    .flag_full    (flag_full),
    .ovf_flag     (ovf_flag),
    .cnt          (cnt),
    .q_state      (q_state),
    .fifo_word    (fifo_word)
);

// File: tb/tb_char_rx_fifo.sv
module tb_char_rx_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 256;

    logic       clk = 1'b0;
    logic       rst_n, fifo_rst_req, bypass, pol_hi, oe;
    logic       wr_en, wr_cmd, rd_en;
    logic [7:0] wr_char;
    logic [7:0] rd_char;
    logic       rd_cmd, flag_empty, flag_half, flag_full, ovf_flag;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    char_rx_fifo dut (
        .clk(clk), .rst_n(rst_n), .fifo_rst_req(fifo_rst_req), .bypass(bypass),
        .pol_hi(pol_hi), .oe(oe), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_char(wr_char),
        .rd_en(rd_en), .rd_char(rd_char), .rd_cmd(rd_cmd), .flag_empty(flag_empty),
        .flag_half(flag_half), .flag_full(flag_full), .ovf_flag(ovf_flag)
    );

    function automatic logic [8:0] pat(int i);
        logic [7:0] v;
        v = 8'(i * 37 + 5);
        return {(i % 3) == 0, v};
    endfunction

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic pin(logic act);
        return pol_hi ? act : !act;
    endfunction

    // flags for FIFO mode with oe high, given an occupancy c
    task automatic chk_flags(string req, int c);
        logic e, h, f;
        e = (c == 0);
        h = (c >= DEPTH / 2);
        f = ((DEPTH - c) <= 4);
        chk(req, {29'd0, flag_empty, flag_half, flag_full},
            {29'd0, pin(e), h, pin(f)});
    endtask

    task automatic chk_word(string req, logic [8:0] exp);
        chk(req, {23'd0, rd_cmd, rd_char}, {23'd0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; fifo_rst_req = 1'b0; bypass = 1'b0; pol_hi = 1'b1; oe = 1'b1;
        wr_en = 1'b0; wr_cmd = 1'b0; wr_char = '0; rd_en = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk_flags("R1 flags", 0);
        chk("R1 ovf", {31'd0, ovf_flag}, 32'd0);
        chk_word("R1 bus", 9'd0);

        // fill sweep: R5 R6 R7 at every occupancy
        for (int i = 0; i < DEPTH; i++) begin
            wr_en = 1'b1;
            {wr_cmd, wr_char} = pat(i);
            tick();
            chk_flags("R5 R6 R7 fill", i + 1);
        end
        wr_en = 1'b0;

        // R3 overflow drop
        wr_en = 1'b1; {wr_cmd, wr_char} = 9'h1AA;
        tick();
        wr_en = 1'b0;
        chk("R3 ovf set", {31'd0, ovf_flag}, 32'd1);
        chk_flags("R3 still full", DEPTH);

        // R10 polarity strap
        pol_hi = 1'b0; #1;
        chk_flags("R10 active low full", DEPTH);
        pol_hi = 1'b1; #1;

        // R12 output enable
        oe = 1'b0; #1;
        chk("R12 flags hi", {29'd0, flag_empty, flag_half, flag_full}, 32'd0);
        chk_word("R12 bus", 9'd0);
        pol_hi = 1'b0; #1;
        chk("R12 flags lo", {29'd0, flag_empty, flag_half, flag_full}, 32'b101);
        pol_hi = 1'b1; oe = 1'b1; #1;

        // R2 drain first half in order
        for (int i = 0; i < DEPTH / 2; i++) begin
            rd_en = 1'b1;
            tick();
            chk_word("R2 order", pat(i));
            chk_flags("R2 R6 R7 drain", DEPTH - i - 1);
        end

        // R8 paired read/write at half boundary
        for (int k = 0; k < 20; k++) begin
            rd_en = 1'b1; wr_en = 1'b1;
            {wr_cmd, wr_char} = pat(DEPTH + k);
            tick();
            chk_word("R8 data", pat(DEPTH / 2 + k));
            chk_flags("R8 occupancy", DEPTH / 2);
        end
        rd_en = 1'b0; wr_en = 1'b0;

        // R9 six-cycle request has no effect
        fifo_rst_req = 1'b1;
        repeat (6) tick();
        fifo_rst_req = 1'b0;
        tick();
        chk_flags("R9 short request", DEPTH / 2);
        chk("R3 R9 ovf kept", {31'd0, ovf_flag}, 32'd1);

        // R11 bypass
        bypass = 1'b1;
        wr_en = 1'b1; {wr_cmd, wr_char} = 9'h03C;
        tick();
        chk_word("R11 data bus", 9'h03C);
        chk("R11 data flags", {29'd0, flag_empty, flag_half, flag_full}, 32'b000);
        {wr_cmd, wr_char} = 9'h11B;
        tick();
        chk_word("R11 cmd bus", 9'h11B);
        chk("R11 cmd flags", {29'd0, flag_empty, flag_half, flag_full}, 32'b100);
        wr_en = 1'b0; rd_en = 1'b1;
        tick();
        chk("R11 idle flags", {29'd0, flag_empty, flag_half, flag_full}, 32'b101);
        chk_word("R11 bus kept", 9'h11B);
        bypass = 1'b0; rd_en = 1'b0; #1;
        chk_flags("R11 store untouched", DEPTH / 2);

        // drain rest: R2 R5
        for (int j = 0; j < DEPTH / 2; j++) begin
            rd_en = 1'b1;
            tick();
            chk_word("R2 order tail", pat(DEPTH / 2 + 20 + j));
            chk_flags("R5 R6 drain tail", DEPTH / 2 - j - 1);
        end

        // R4 reads on empty
        for (int j = 0; j < 3; j++) begin
            rd_en = 1'b1;
            tick();
            chk_word("R4 bus held", pat(DEPTH + 19));
            chk_flags("R4 flags", 0);
        end
        rd_en = 1'b0;

        // R9 qualified clear
        for (int i = 0; i < 200; i++) begin
            wr_en = 1'b1; {wr_cmd, wr_char} = pat(500 + i);
            tick();
        end
        wr_en = 1'b0;
        chk_flags("R9 before clear", 200);
        fifo_rst_req = 1'b1;
        repeat (7) tick();
        chk_flags("R9 cleared", 0);
        chk("R9 ovf cleared", {31'd0, ovf_flag}, 32'd0);
        wr_en = 1'b1; {wr_cmd, wr_char} = 9'h055;
        repeat (3) tick();
        chk_flags("R9 writes ignored", 0);
        wr_en = 1'b0; fifo_rst_req = 1'b0;
        tick();
        chk_flags("R9 released", 0);

        wr_en = 1'b1; {wr_cmd, wr_char} = 9'h1E7;
        tick();
        wr_en = 1'b0; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk_word("R2 after clear", 9'h1E7);
        chk_flags("R5 after clear", 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule